// File: doc/BRIEF.md
# Private System Region Decoder with Secure Banking

This block sits in front of the 1 MB private system region of a processor subsystem and decides, for every request, which register target answers it. The request carries an offset inside the region plus a secure attribute and an unprivileged (user) attribute. The targets overlap, and a fixed priority picks the winner. The targets are a system control block, a timer bank split into a secure and a non-secure instance, an optional RAS register block, and a default responder. Offsets that no target claims read as zero and drop writes for privileged code. Unprivileged code gets a bus error from those offsets.

When the security feature is built in, a second window repeats the control block and the timer bank at a fixed distance. Secure software uses it to reach the non-secure copies. A secure access there is sent on to the matching main target with its offset moved back into the main window and the secure attribute cleared. A non-secure access there behaves like an unclaimed offset.

Decoding happens in the cycle the request is accepted. The target selects, the forwarded offset, the write strobe, the write data and the forwarded secure attribute are valid only in that cycle. The read data or the error is registered and returned one cycle later over a ready/valid response. A two-state machine runs the exchange. ST_IDLE accepts one request (transition ACCEPT) and moves to ST_RESP. ST_RESP presents the response until it is taken (transition RELEASE) and then returns to ST_IDLE.

Top module: `sysreg_space_decoder`

## Requirements
- R1: A privileged request to an offset that no target claims asserts no select. It completes with read data 0 and rsp_error 0.
- R2: An unprivileged request to an unclaimed offset asserts no select. It completes with rsp_error 1 and read data 0.
- R3: Offsets 0xE000 to 0xEFFF, outside the timer window, assert sel_scb. The secure attribute goes out unchanged on fwd_secure and the offset goes out unchanged on tgt_addr.
- R4: Offsets 0xE010 to 0xE0EF override the control block. A secure request there asserts sel_tmr_s and a non-secure one asserts sel_tmr_ns.
- R5: With HAS_RAS set, offsets 0x5000 to 0x5FFF assert sel_ras. With HAS_RAS clear, they are unclaimed.
- R6: With HAS_SECURITY set, a secure request to offsets 0x2E000 to 0x2EFFF is sent on with 0x20000 subtracted from tgt_addr and with fwd_secure 0. Offsets 0x2E010 to 0x2E0EF go to sel_tmr_ns and the rest of that window goes to sel_scb.
- R7: A non-secure request to the alias window asserts no select. It is RAZ/WI when privileged and completes with rsp_error 1 when unprivileged.
- R8: With HAS_SECURITY clear, sel_tmr_s is never asserted and the alias window is unclaimed.
- R9: Select lines are asserted only in the accept cycle (req_valid and req_ready both high), and at most one at a time. The selected target's read data, or 0 for an unclaimed offset, appears on rsp_rdata with rsp_valid one cycle after the accept.
- R10: While rsp_valid is high, req_ready is low and no select is asserted. rsp_valid, rsp_rdata and rsp_error stay stable until rsp_ready is seen high.
- R11: A write asserts tgt_write and carries req_wdata on tgt_wdata in the accept cycle. Its response has rsp_rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | OFF_W | Byte offset inside the private region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_secure | input | 1 | Secure attribute of the request |
| req_user | input | 1 | Unprivileged attribute of the request |
| sel_scb | output | 1 | Select for the system control block |
| sel_tmr_s | output | 1 | Select for the secure timer bank |
| sel_tmr_ns | output | 1 | Select for the non-secure timer bank |
| sel_ras | output | 1 | Select for the RAS block |
| tgt_addr | output | OFF_W | Offset sent to the selected target |
| tgt_write | output | 1 | Write strobe sent to the target |
| tgt_wdata | output | DATA_W | Write data sent to the target |
| fwd_secure | output | 1 | Secure attribute sent to the target |
| scb_rdata | input | DATA_W | Read data from the control block |
| tmr_s_rdata | input | DATA_W | Read data from the secure timer |
| tmr_ns_rdata | input | DATA_W | Read data from the non-secure timer |
| ras_rdata | input | DATA_W | Read data from the RAS block |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DATA_W | Response read data |
| rsp_error | output | 1 | Bus error for the request |

## Verification
The assertions assume that the targets return their read data in the same cycle as their select. They also assume that req_user keeps its value through the accept cycle, so that an error can be traced back to the request that caused it. The stimulus holds every request field constant from one falling edge to the next. It drives constant target read data, and it holds rsp_ready low until a response is pending. Addresses are drawn mostly from narrow buckets around each window edge. Two instances run side by side: one with both options built in and one with neither. This way the same offsets exercise both the banked decode and the decode without the options.

// File: rtl/sysreg_space_pkg.sv
`timescale 1ns/1ps
package sysreg_space_pkg;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_SCB    = 3'd1,
        TGT_TMR_S  = 3'd2,
        TGT_TMR_NS = 3'd3,
        TGT_RAS    = 3'd4
    } tgt_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/sysreg_space_decode.sv
`timescale 1ns/1ps
module sysreg_space_decode
    import sysreg_space_pkg::*;
#(
    parameter int unsigned OFF_W        = 20,
    parameter bit          HAS_SECURITY = 1'b1,
    parameter bit          HAS_RAS      = 1'b1,
    parameter int unsigned SCB_BASE     = 32'h0000_E000,
    parameter int unsigned SCB_SIZE     = 32'h0000_1000,
    parameter int unsigned TMR_BASE     = 32'h0000_E010,
    parameter int unsigned TMR_SIZE     = 32'h0000_00E0,
    parameter int unsigned RAS_BASE     = 32'h0000_5000,
    parameter int unsigned RAS_SIZE     = 32'h0000_1000,
    parameter int unsigned ALIAS_DELTA  = 32'h0002_0000
) (
    input  logic [OFF_W-1:0] addr,
    input  logic             secure,
    input  logic             user,
    output tgt_e             tgt,
    output logic             fwd_sec,
    output logic             fault,
    output logic [OFF_W-1:0] tgt_addr
);

    localparam logic [OFF_W-1:0] SCB_LO  = OFF_W'(SCB_BASE);
    localparam logic [OFF_W-1:0] SCB_HI  = OFF_W'(SCB_BASE + SCB_SIZE - 1);
    localparam logic [OFF_W-1:0] TMR_LO  = OFF_W'(TMR_BASE);
    localparam logic [OFF_W-1:0] TMR_HI  = OFF_W'(TMR_BASE + TMR_SIZE - 1);
    localparam logic [OFF_W-1:0] RAS_LO  = OFF_W'(RAS_BASE);
    localparam logic [OFF_W-1:0] RAS_HI  = OFF_W'(RAS_BASE + RAS_SIZE - 1);
    localparam logic [OFF_W-1:0] ASCB_LO = OFF_W'(SCB_BASE + ALIAS_DELTA);
    localparam logic [OFF_W-1:0] ASCB_HI = OFF_W'(SCB_BASE + SCB_SIZE - 1 + ALIAS_DELTA);
    localparam logic [OFF_W-1:0] ATMR_LO = OFF_W'(TMR_BASE + ALIAS_DELTA);
    localparam logic [OFF_W-1:0] ATMR_HI = OFF_W'(TMR_BASE + TMR_SIZE - 1 + ALIAS_DELTA);
    localparam logic [OFF_W-1:0] DELTA   = OFF_W'(ALIAS_DELTA);

    logic hit_scb;
    logic hit_tmr;
    logic hit_ras;
    logic hit_ascb;
    logic hit_atmr;

    assign hit_scb = (addr >= SCB_LO) && (addr <= SCB_HI);
    assign hit_tmr = (addr >= TMR_LO) && (addr <= TMR_HI);

    // optional RAS window
    generate
        if (HAS_RAS) begin : g_ras
            assign hit_ras = (addr >= RAS_LO) && (addr <= RAS_HI);
        end else begin : g_no_ras
            assign hit_ras = 1'b0;
        end
    endgenerate

    // alias window exists only with the security feature
    generate
        if (HAS_SECURITY) begin : g_alias
            assign hit_ascb = (addr >= ASCB_LO) && (addr <= ASCB_HI);
            assign hit_atmr = (addr >= ATMR_LO) && (addr <= ATMR_HI);
        end else begin : g_no_alias
            assign hit_ascb = 1'b0;
            assign hit_atmr = 1'b0;
        end
    endgenerate

    // priority: timer / RAS over control block over alias over default
    always_comb begin
        tgt      = TGT_NONE;
        fwd_sec  = secure;
        fault    = user;
        tgt_addr = addr;
        if (hit_tmr) begin
            tgt   = (secure && HAS_SECURITY) ? TGT_TMR_S : TGT_TMR_NS;
            fault = 1'b0;
        end else if (hit_ras) begin
            tgt   = TGT_RAS;
            fault = 1'b0;
        end else if (hit_scb) begin
            tgt   = TGT_SCB;
            fault = 1'b0;
        end else if (hit_ascb) begin
            if (secure) begin
                tgt      = hit_atmr ? TGT_TMR_NS : TGT_SCB;
                fwd_sec  = 1'b0;
                fault    = 1'b0;
                tgt_addr = addr - DELTA;
            end
        end
    end

endmodule

// File: rtl/sysreg_space_rsp_fsm.sv
`timescale 1ns/1ps
module sysreg_space_rsp_fsm
    import sysreg_space_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    output logic              accept,
    input  logic [DATA_W-1:0] cap_rdata,
    input  logic              cap_error,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error
);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              error_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ACCEPT (idle -> resp), RELEASE (resp -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = req_valid && req_ready;

    // response capture at ACCEPT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            error_q <= 1'b0;
        end else if (accept) begin
            rdata_q <= cap_rdata;
            error_q <= cap_error;
        end
    end

    assign rsp_rdata = rdata_q;
    assign rsp_error = error_q;

endmodule

// File: rtl/sysreg_space_decoder.sv
`timescale 1ns/1ps
module sysreg_space_decoder
    import sysreg_space_pkg::*;
#(
    parameter int unsigned OFF_W        = 20,
    parameter int unsigned DATA_W       = 32,
    parameter bit          HAS_SECURITY = 1'b1,
    parameter bit          HAS_RAS      = 1'b1,
    parameter int unsigned SCB_BASE     = 32'h0000_E000,
    parameter int unsigned SCB_SIZE     = 32'h0000_1000,
    parameter int unsigned TMR_BASE     = 32'h0000_E010,
    parameter int unsigned TMR_SIZE     = 32'h0000_00E0,
    parameter int unsigned RAS_BASE     = 32'h0000_5000,
    parameter int unsigned RAS_SIZE     = 32'h0000_1000,
    parameter int unsigned ALIAS_DELTA  = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OFF_W-1:0]  req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    input  logic              req_user,
    output logic              sel_scb,
    output logic              sel_tmr_s,
    output logic              sel_tmr_ns,
    output logic              sel_ras,
    output logic [OFF_W-1:0]  tgt_addr,
    output logic              tgt_write,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              fwd_secure,
    input  logic [DATA_W-1:0] scb_rdata,
    input  logic [DATA_W-1:0] tmr_s_rdata,
    input  logic [DATA_W-1:0] tmr_ns_rdata,
    input  logic [DATA_W-1:0] ras_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error
);

    localparam logic [OFF_W-1:0] ALIAS_LO = OFF_W'(SCB_BASE + ALIAS_DELTA);
    localparam logic [OFF_W-1:0] ALIAS_HI = OFF_W'(SCB_BASE + SCB_SIZE - 1 + ALIAS_DELTA);

    tgt_e              dec_tgt;
    logic              dec_fault;
    logic              accept;
    logic [DATA_W-1:0] pick_rdata;
    logic [DATA_W-1:0] cap_rdata;

    sysreg_space_decode #(
        .OFF_W        (OFF_W),
        .HAS_SECURITY (HAS_SECURITY),
        .HAS_RAS      (HAS_RAS),
        .SCB_BASE     (SCB_BASE),
        .SCB_SIZE     (SCB_SIZE),
        .TMR_BASE     (TMR_BASE),
        .TMR_SIZE     (TMR_SIZE),
        .RAS_BASE     (RAS_BASE),
        .RAS_SIZE     (RAS_SIZE),
        .ALIAS_DELTA  (ALIAS_DELTA)
    ) i_decode (
        .addr     (req_addr),
        .secure   (req_secure),
        .user     (req_user),
        .tgt      (dec_tgt),
        .fwd_sec  (fwd_secure),
        .fault    (dec_fault),
        .tgt_addr (tgt_addr)
    );

    sysreg_space_rsp_fsm #(
        .DATA_W (DATA_W)
    ) i_rsp_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .cap_rdata (cap_rdata),
        .cap_error (dec_fault),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata),
        .rsp_error (rsp_error)
    );

    // selects only during the accept cycle
    assign sel_scb    = accept && (dec_tgt == TGT_SCB);
    assign sel_tmr_s  = accept && (dec_tgt == TGT_TMR_S);
    assign sel_tmr_ns = accept && (dec_tgt == TGT_TMR_NS);
    assign sel_ras    = accept && (dec_tgt == TGT_RAS);
    assign tgt_write  = accept && req_write;
    assign tgt_wdata  = req_wdata;

    always_comb begin
        unique case (dec_tgt)
            TGT_SCB:    pick_rdata = scb_rdata;
            TGT_TMR_S:  pick_rdata = tmr_s_rdata;
            TGT_TMR_NS: pick_rdata = tmr_ns_rdata;
            TGT_RAS:    pick_rdata = ras_rdata;
            default:    pick_rdata = '0;
        endcase
    end

    assign cap_rdata = (req_write || dec_fault) ? '0 : pick_rdata;

    logic [3:0] sel_vec;
    assign sel_vec = {sel_scb, sel_tmr_s, sel_tmr_ns, sel_ras};

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec)); // R9
    AST_SEL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|sel_vec) |-> (req_valid && req_ready)); // R9
    AST_SEC_TIMER_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_tmr_s |-> req_secure); // R4
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_error))); // R10
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && !(|sel_vec))); // R10
    AST_FAULT_USER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_error) |-> $past(req_user)); // R2
    AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> (rsp_rdata == '0)); // R7
    AST_ALIAS_CLEARS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sel_vec) && (req_addr >= ALIAS_LO) && (req_addr <= ALIAS_HI)) |-> !fwd_secure); // R6

endmodule

// File: tb/test_sysreg_space_decoder.sv
`timescale 1ns/1ps
module test_sysreg_space_decoder;

    localparam int unsigned OFF_W  = 20;
    localparam int unsigned DATA_W = 32;
    localparam logic [DATA_W-1:0] D_SCB   = 32'hC0DE_0001;
    localparam logic [DATA_W-1:0] D_TMR_S = 32'h5EC0_0002;
    localparam logic [DATA_W-1:0] D_TMR_N = 32'h0A50_0003;
    localparam logic [DATA_W-1:0] D_RAS   = 32'hBA55_0004;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [OFF_W-1:0]  req_addr = '0;
    logic              req_write = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_secure = 1'b0;
    logic              req_user = 1'b0;
    logic              rsp_ready = 1'b0;

    logic              a_rdy, a_scb, a_ts, a_tn, a_ras, a_tw, a_fs, a_rv, a_re;
    logic [OFF_W-1:0]  a_ta;
    logic [DATA_W-1:0] a_wd, a_rd;
    logic              b_rdy, b_scb, b_ts, b_tn, b_ras, b_tw, b_fs, b_rv, b_re;
    logic [OFF_W-1:0]  b_ta;
    logic [DATA_W-1:0] b_wd, b_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sysreg_space_decoder #(.HAS_SECURITY(1'b1), .HAS_RAS(1'b1)) i_sysreg_space_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_rdy),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_secure(req_secure), .req_user(req_user),
        .sel_scb(a_scb), .sel_tmr_s(a_ts), .sel_tmr_ns(a_tn), .sel_ras(a_ras),
        .tgt_addr(a_ta), .tgt_write(a_tw), .tgt_wdata(a_wd), .fwd_secure(a_fs),
        .scb_rdata(D_SCB), .tmr_s_rdata(D_TMR_S), .tmr_ns_rdata(D_TMR_N), .ras_rdata(D_RAS),
        .rsp_valid(a_rv), .rsp_ready(rsp_ready), .rsp_rdata(a_rd), .rsp_error(a_re));

    sysreg_space_decoder #(.HAS_SECURITY(1'b0), .HAS_RAS(1'b0)) i_sysreg_space_decoder_bare (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_rdy),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_secure(req_secure), .req_user(req_user),
        .sel_scb(b_scb), .sel_tmr_s(b_ts), .sel_tmr_ns(b_tn), .sel_ras(b_ras),
        .tgt_addr(b_ta), .tgt_write(b_tw), .tgt_wdata(b_wd), .fwd_secure(b_fs),
        .scb_rdata(D_SCB), .tmr_s_rdata(D_TMR_S), .tmr_ns_rdata(D_TMR_N), .ras_rdata(D_RAS),
        .rsp_valid(b_rv), .rsp_ready(rsp_ready), .rsp_rdata(b_rd), .rsp_error(b_re));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected decode: {code[2:0], fwd_sec, err, tgt_addr[19:0]}
    // code 0 none, 1 control block, 2 secure timer, 3 non-secure timer, 4 RAS
    function automatic logic [24:0] model(input logic [OFF_W-1:0] a, input bit sec,
                                          input bit usr, input bit hs, input bit hr);
        logic [2:0] code = 3'd0;
        logic fs = sec;
        logic er = usr;
        logic [OFF_W-1:0] ta = a;
        if (a >= 20'hE010 && a <= 20'hE0EF) begin
            code = (sec && hs) ? 3'd2 : 3'd3; er = 1'b0;
        end else if (hr && a >= 20'h5000 && a <= 20'h5FFF) begin
            code = 3'd4; er = 1'b0;
        end else if (a >= 20'hE000 && a <= 20'hEFFF) begin
            code = 3'd1; er = 1'b0;
        end else if (hs && a >= 20'h2E000 && a <= 20'h2EFFF && sec) begin
            er = 1'b0; fs = 1'b0; ta = a - 20'h20000;
            code = (a >= 20'h2E010 && a <= 20'h2E0EF) ? 3'd3 : 3'd1;
        end
        return {code, fs, er, ta};
    endfunction

    function automatic logic [3:0] sel_of(input logic [2:0] code);
        case (code)
            3'd1: return 4'b1000;
            3'd2: return 4'b0100;
            3'd3: return 4'b0010;
            3'd4: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] data_of(input logic [2:0] code, input bit wr, input bit er);
        if (wr || er) return 32'h0;
        case (code)
            3'd1: return D_SCB;
            3'd2: return D_TMR_S;
            3'd3: return D_TMR_N;
            3'd4: return D_RAS;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [OFF_W-1:0] a, input bit sec, input bit usr,
                                     input bit hs, input bit hr, input logic [2:0] code);
        bit in_alias = (a >= 20'h2E000 && a <= 20'h2EFFF);
        bit in_ras = (a >= 20'h5000 && a <= 20'h5FFF);
        if (!hs && (in_alias || code == 3'd3 || code == 3'd2)) return "R8";
        if (in_alias && !sec) return "R7";
        if (in_alias) return "R6";
        if (in_ras) return "R5";
        if (code == 3'd2 || code == 3'd3) return "R4";
        if (code == 3'd1) return "R3";
        return usr ? "R2" : "R1";
    endfunction

    task automatic txn(input logic [OFF_W-1:0] a, input bit sec, input bit usr,
                       input bit wr, input bit hold);
        logic [24:0] ea = model(a, sec, usr, 1'b1, 1'b1);
        logic [24:0] eb = model(a, sec, usr, 1'b0, 1'b0);
        string ta = tag_of(a, sec, usr, 1'b1, 1'b1, ea[24:22]);
        string tb = tag_of(a, sec, usr, 1'b0, 1'b0, eb[24:22]);
        logic [31:0] wd = $urandom;
        logic [31:0] held;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_secure = sec; req_user = usr;
        req_write = wr; req_wdata = wd;
        #1;
        chk(a_rdy && b_rdy, "R10 ready when idle", {30'd0, a_rdy, b_rdy}, 32'h3);
        chk({a_scb, a_ts, a_tn, a_ras} == sel_of(ea[24:22]), ta, {28'd0, a_scb, a_ts, a_tn, a_ras}, {28'd0, sel_of(ea[24:22])});
        chk({b_scb, b_ts, b_tn, b_ras} == sel_of(eb[24:22]), tb, {28'd0, b_scb, b_ts, b_tn, b_ras}, {28'd0, sel_of(eb[24:22])});
        if (ea[24:22] != 3'd0) begin
            chk(a_fs == ea[21], {ta, " fwd_secure"}, {31'd0, a_fs}, {31'd0, ea[21]});
            chk(a_ta == ea[19:0], {ta, " tgt_addr"}, {12'd0, a_ta}, {12'd0, ea[19:0]});
        end
        if (eb[24:22] != 3'd0) begin
            chk(b_fs == eb[21], {tb, " fwd_secure"}, {31'd0, b_fs}, {31'd0, eb[21]});
        end
        chk(a_tw == wr && (!wr || a_wd == wd), "R11 write forward", {31'd0, a_tw}, {31'd0, wr});
        @(negedge clk);
        req_valid = 1'b0;
        rsp_ready = !hold;
        #1;
        chk(a_rv && b_rv, "R9 response one cycle after accept", {30'd0, a_rv, b_rv}, 32'h3);
        chk({a_scb, a_ts, a_tn, a_ras, b_scb, b_ts, b_tn, b_ras} == 8'h0, "R9 selects drop after accept",
            {24'd0, a_scb, a_ts, a_tn, a_ras, b_scb, b_ts, b_tn, b_ras}, 32'h0);
        chk(a_re == ea[20], {ta, " error"}, {31'd0, a_re}, {31'd0, ea[20]});
        chk(b_re == eb[20], {tb, " error"}, {31'd0, b_re}, {31'd0, eb[20]});
        chk(a_rd == data_of(ea[24:22], wr, ea[20]), wr ? "R11 write rdata" : {ta, " rdata"},
            a_rd, data_of(ea[24:22], wr, ea[20]));
        chk(b_rd == data_of(eb[24:22], wr, eb[20]), wr ? "R11 write rdata" : {tb, " rdata"},
            b_rd, data_of(eb[24:22], wr, eb[20]));
        if (hold) begin
            held = a_rd;
            req_valid = 1'b1; req_addr = 20'hE020; req_secure = 1'b1; req_user = 1'b0; req_write = 1'b0;
            #1;
            chk(!a_rdy && {a_scb, a_ts, a_tn, a_ras} == 4'h0, "R10 no accept while busy",
                {27'd0, a_rdy, a_scb, a_ts, a_tn, a_ras}, 32'h0);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(a_rv && a_rd == held, "R10 response held", a_rd, held);
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        rsp_ready = 1'b0;
        #1;
        chk(!a_rv && a_rdy && !b_rv && b_rdy, "R10 release", {28'd0, a_rv, a_rdy, b_rv, b_rdy}, 32'h5);
    endtask

    function automatic logic [OFF_W-1:0] pick_addr();
        logic [OFF_W-1:0] bases[8] = '{20'hE000, 20'hE010, 20'hE0F0, 20'h5000,
                                       20'h2E000, 20'h2E010, 20'h2F000, 20'h00000};
        int k = $urandom % 8;
        int d = int'($urandom % 9) - 4;
        if (($urandom % 4) == 0) return 20'($urandom);
        return bases[k] + 20'(d);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed_v;
        seed_v = $urandom(32'h00C0_FFEE);
        repeat (3) @(negedge clk);
        #1;
        chk(!a_rv && !b_rv && a_rdy && b_rdy, "R9 reset state", {28'd0, a_rv, b_rv, a_rdy, b_rdy}, 32'h3);
        rst_n = 1'b1;
        // directed corners
        txn(20'h0DFFF, 0, 0, 0, 0);   // R1
        txn(20'h01000, 0, 1, 0, 0);   // R2
        txn(20'h0E000, 1, 0, 0, 0);   // R3
        txn(20'h0E00F, 0, 1, 0, 0);   // R3
        txn(20'h0E010, 1, 0, 0, 0);   // R4
        txn(20'h0E0EF, 0, 0, 0, 0);   // R4
        txn(20'h0E0F0, 1, 0, 0, 1);   // R3 R10
        txn(20'h0EFFF, 0, 0, 1, 0);   // R11
        txn(20'h0F000, 0, 1, 0, 0);   // R2
        txn(20'h04FFF, 0, 0, 0, 0);   // R5 edge
        txn(20'h05000, 1, 1, 0, 0);   // R5
        txn(20'h05FFF, 0, 0, 0, 0);   // R5
        txn(20'h2E000, 1, 0, 0, 0);   // R6
        txn(20'h2E010, 1, 0, 0, 0);   // R6
        txn(20'h2E0EF, 1, 1, 1, 0);   // R6 R11
        txn(20'h2E0F0, 1, 0, 0, 0);   // R6
        txn(20'h2EFFF, 1, 0, 0, 0);   // R6
        txn(20'h2E010, 0, 0, 0, 0);   // R7
        txn(20'h2E800, 0, 1, 0, 0);   // R7
        txn(20'h2F000, 1, 1, 0, 0);   // R2
        txn(20'h2DFFF, 1, 0, 0, 0);   // R1
        // random mix
        for (int i = 0; i < 600; i++) begin
            txn(pick_addr(), 1'($urandom), 1'($urandom), 1'($urandom), (($urandom % 5) == 0));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule